// File: doc/BRIEF.md
# Vectored Sixteen-Source Interrupt Controller

This block gathers sixteen interrupt sources into one request line and answers each acknowledge with an 8-bit vector. Eight sources come from general-purpose pins. Each pin has a programmable active transition and a programmable direction. The other eight sources come from single-cycle event pulses raised by neighbouring peripherals. The sources are organised as two 8-bit banks. Bank B holds sources 0 to 7 and bank A holds sources 8 to 15. Each bank has its own enable, pending, in-service and mask byte.

Software reaches the controller through a small byte-wide register port with an address, write data, a write strobe and a registered read-data output. The interrupt-accepting side raises `iack` for one cycle and receives the vector one cycle later. A mode bit in the vector register selects one of two end-of-interrupt modes. In automatic mode, acknowledging a source finishes it. In software mode, the acknowledged source is marked in service, and that source and every lower-priority source stay held off until software clears the mark.

Top module: `vic16`

## Requirements
- R1: The register indices are: 0 pin data, 1 edge select, 2 direction, 3 enable A, 4 enable B, 5 pending A, 6 pending B, 7 in-service A, 8 in-service B, 9 mask A, 10 mask B, 11 vector. Every register resets to 0. `reg_rdata` shows the register at `reg_addr` one cycle after the address is presented. Unused indices read 0, and writes to them are ignored. Bits 2:0 of the vector register read 0.
- R2: Pin i drives source i (bank B bit i). Edge-select bit 1 means a rising transition raises the event and 0 means a falling one. Direction bit 1 makes the pin an output, and such a pin raises no event. `pin_oe` equals the direction register and `pin_out` equals the written pin data. Reading index 0 returns the written data for output pins and the `pin_in` level for input pins.
- R3: `src_evt[j]` drives source 8+j (bank A bit j).
- R4: A pending bit sets on its source's event only when the enable bit for that source is 1. Writing an enable bit to 0 also clears that source's pending bit.
- R5: A mask bit of 1 lets a pending source request, and 0 blocks it. A masked source still latches its pending bit. `irq` is registered: it is 1 one cycle after some source is pending, unmasked and not held off.
- R6: Source 15 has the highest priority and source 0 the lowest. On `iack`, the highest-priority requesting source has its pending bit cleared. One cycle later `vec_valid` pulses with `vec` = {vector register bits 7:4, source number}. An `iack` with no requesting source leaves `vec_valid` at 0.
- R7: With vector register bit 3 set (software mode), an acknowledge also sets the source's in-service bit. That source and all lower-numbered sources are then held off until software writes the bit to 0, while higher-numbered sources may still be acknowledged.
- R8: With vector register bit 3 clear (automatic mode), the in-service registers read 0 from the cycle after the mode is in effect.
- R9: Writing a pending or in-service register clears the bits written as 0 and leaves the bits written as 1 unchanged.
- R10: An event that arrives in the same cycle as a write that clears its pending bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output data |
| pin_oe | output | 8 | Pin output enables |
| src_evt | input | 8 | Peripheral event pulses, sources 8 to 15 |
| irq | output | 1 | Interrupt request |
| iack | input | 1 | Acknowledge pulse |
| vec_valid | output | 1 | Vector valid pulse |
| vec | output | 8 | Supplied vector |

## Verification
The assertions watch invariants on every cycle. No pending bit survives with its enable clear. The in-service registers stay empty in automatic mode. An in-service bit rises only after an acknowledge in software mode. A vector appears only after an acknowledge and carries the programmed high nibble. A request needs an unmasked pending source. Priority order, hold-off of lower sources, the write-to-clear rules, event-versus-clear collisions and per-pin edge and direction handling are shown only by the bench scenarios. Those scenarios compare every read, request and vector against a reference model.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  // register indices (order is the software-visible map)
  localparam int RA_PIN   = 0;
  localparam int RA_EDGE  = 1;
  localparam int RA_DIR   = 2;
  localparam int RA_ENA_A = 3;
  localparam int RA_ENA_B = 4;
  localparam int RA_PND_A = 5;
  localparam int RA_PND_B = 6;
  localparam int RA_SRV_A = 7;
  localparam int RA_SRV_B = 8;
  localparam int RA_MSK_A = 9;
  localparam int RA_MSK_B = 10;
  localparam int RA_VEC   = 11;
  // vector register bit that selects software end-of-interrupt
  localparam int MODE_BIT = 3;
endpackage

// File: rtl/vic_pin_edge.sv
`timescale 1ns/1ps
module vic_pin_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] edge_sel,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_ff @(posedge clk) prev[i] <= pin[i];
    // transition towards the selected level, inputs only
    assign evt[i] = ~dir[i] & (prev[i] ^ pin[i]) & ~(pin[i] ^ edge_sel[i]);
  end
endmodule

// File: rtl/vic_prio.sv
`timescale 1ns/1ps
module vic_prio #(
  parameter int N   = 16,
  parameter int IDW = 4
) (
  input  logic [N-1:0]   pend,
  input  logic [N-1:0]   mask,
  input  logic [N-1:0]   srv,
  output logic           any,
  output logic [IDW-1:0] id,
  output logic [N-1:0]   grant
);
  logic [N-1:0] hold;
  logic [N-1:0] elig;
  logic         acc;

  // a source is held off while it or any higher source is in service
  always_comb begin
    acc = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      acc     = acc | srv[k];
      hold[k] = acc;
    end
  end

  assign elig = pend & mask & ~hold;
  assign any  = |elig;

  always_comb begin
    id = '0;
    for (int k = 0; k < N; k++)
      if (elig[k]) id = IDW'(k);
    grant = '0;
    if (any) grant[id] = 1'b1;
  end
endmodule

// File: rtl/vic16.sv
`timescale 1ns/1ps
module vic16 import vic_pkg::*; #(
  parameter int BW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic [BW-1:0] reg_wdata,
  input  logic          reg_wr,
  output logic [BW-1:0] reg_rdata,
  input  logic [BW-1:0] pin_in,
  output logic [BW-1:0] pin_out,
  output logic [BW-1:0] pin_oe,
  input  logic [BW-1:0] src_evt,
  output logic          irq,
  input  logic          iack,
  output logic          vec_valid,
  output logic [BW-1:0] vec
);
  localparam int NS  = 2 * BW;
  localparam int IDW = $clog2(NS);
  localparam logic [BW-1:0] VR_KEEP = ~((BW'(1) << MODE_BIT) - BW'(1));

  logic [BW-1:0] out_q, edge_q, dir_q, vr_q;
  logic [NS-1:0] en_q, pend_q, srv_q, mask_q;
  logic [NS-1:0] en_n, pend_n, srv_n;
  logic [BW-1:0] pin_evt, rd_n;
  logic [NS-1:0] src_all, grant;
  logic          any, sw_mode;
  logic [IDW-1:0] id;
  logic          irq_q, vv_q;
  logic [BW-1:0] vec_q, rdata_q;

  function automatic logic hit(input logic wr, input logic [AW-1:0] a, input int idx);
    return wr && (a == AW'(idx));
  endfunction

  vic_pin_edge #(.W(BW)) u_edge (
    .clk(clk), .pin(pin_in), .dir(dir_q), .edge_sel(edge_q), .evt(pin_evt)
  );

  assign src_all = {src_evt, pin_evt};
  assign sw_mode = vr_q[MODE_BIT];

  vic_prio #(.N(NS), .IDW(IDW)) u_prio (
    .pend(pend_q), .mask(mask_q), .srv(srv_q),
    .any(any), .id(id), .grant(grant)
  );

  // next state of enable, pending and in-service
  always_comb begin
    en_n = en_q;
    if (hit(reg_wr, reg_addr, RA_ENA_A)) en_n[NS-1:BW] = reg_wdata;
    if (hit(reg_wr, reg_addr, RA_ENA_B)) en_n[BW-1:0]  = reg_wdata;

    pend_n = pend_q;
    if (hit(reg_wr, reg_addr, RA_PND_A)) pend_n[NS-1:BW] = pend_q[NS-1:BW] & reg_wdata;
    if (hit(reg_wr, reg_addr, RA_PND_B)) pend_n[BW-1:0]  = pend_q[BW-1:0] & reg_wdata;

    srv_n = srv_q;
    if (hit(reg_wr, reg_addr, RA_SRV_A)) srv_n[NS-1:BW] = srv_q[NS-1:BW] & reg_wdata;
    if (hit(reg_wr, reg_addr, RA_SRV_B)) srv_n[BW-1:0]  = srv_q[BW-1:0] & reg_wdata;

    if (iack && any) begin
      pend_n = pend_n & ~grant;
      if (sw_mode) srv_n = srv_n | grant;
    end
    if (!sw_mode) srv_n = '0;

    // new events win over clears, disabled sources never hold pending
    pend_n = (pend_n | src_all) & en_n;
  end

  // read multiplexer
  always_comb begin
    rd_n = '0;
    case (reg_addr)
      AW'(RA_PIN):   rd_n = (dir_q & out_q) | (~dir_q & pin_in);
      AW'(RA_EDGE):  rd_n = edge_q;
      AW'(RA_DIR):   rd_n = dir_q;
      AW'(RA_ENA_A): rd_n = en_q[NS-1:BW];
      AW'(RA_ENA_B): rd_n = en_q[BW-1:0];
      AW'(RA_PND_A): rd_n = pend_q[NS-1:BW];
      AW'(RA_PND_B): rd_n = pend_q[BW-1:0];
      AW'(RA_SRV_A): rd_n = srv_q[NS-1:BW];
      AW'(RA_SRV_B): rd_n = srv_q[BW-1:0];
      AW'(RA_MSK_A): rd_n = mask_q[NS-1:BW];
      AW'(RA_MSK_B): rd_n = mask_q[BW-1:0];
      AW'(RA_VEC):   rd_n = vr_q;
      default:       rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      edge_q  <= '0;
      dir_q   <= '0;
      vr_q    <= '0;
      en_q    <= '0;
      pend_q  <= '0;
      srv_q   <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
      vv_q    <= 1'b0;
      vec_q   <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_n;
      pend_q  <= pend_n;
      srv_q   <= srv_n;
      irq_q   <= any;
      vv_q    <= iack && any;
      rdata_q <= rd_n;
      if (iack && any) vec_q <= {vr_q[BW-1:IDW], id};
      if (hit(reg_wr, reg_addr, RA_PIN))   out_q  <= reg_wdata;
      if (hit(reg_wr, reg_addr, RA_EDGE))  edge_q <= reg_wdata;
      if (hit(reg_wr, reg_addr, RA_DIR))   dir_q  <= reg_wdata;
      if (hit(reg_wr, reg_addr, RA_MSK_A)) mask_q[NS-1:BW] <= reg_wdata;
      if (hit(reg_wr, reg_addr, RA_MSK_B)) mask_q[BW-1:0]  <= reg_wdata;
      if (hit(reg_wr, reg_addr, RA_VEC))   vr_q   <= reg_wdata & VR_KEEP;
    end
  end

  assign reg_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign irq       = irq_q;
  assign vec_valid = vv_q;
  assign vec       = vec_q;

  // R4: no pending bit without its enable
  a_r4_pend_enabled: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~en_q) == '0);

  // R8: automatic mode keeps in-service empty
  a_r8_auto_empty: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_mode) |-> srv_q == '0);

  // R7: an in-service bit only rises after an acknowledge in software mode
  a_r7_srv_from_ack: assert property (@(posedge clk) disable iff (rst)
    (|(srv_q & ~$past(srv_q))) |-> ($past(iack) && $past(sw_mode)));

  // R6: a vector only follows an acknowledge
  a_r6_vec_after_ack: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(iack));

  // R6: the vector carries the programmed high nibble
  a_r6_vec_nibble: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> vec[BW-1:IDW] == $past(vr_q[BW-1:IDW]));

  // R5: a request needs an unmasked pending source
  a_r5_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(pend_q & mask_q)));
endmodule

// File: tb/tb_vic16.sv
`timescale 1ns/1ps
module tb_vic16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic [7:0] src_evt = '0;
  logic       irq;
  logic       iack = 1'b0;
  logic       vec_valid;
  logic [7:0] vec;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_en = '0, m_pend = '0, m_srv = '0, m_mask = '0;
  logic [7:0]  m_out = '0, m_edge = '0, m_dir = '0, m_vr = '0, m_prev = '0;
  logic [7:0]  g_pins = '0;

  always #5 clk = ~clk;

  vic16 dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .src_evt(src_evt), .irq(irq),
    .iack(iack), .vec_valid(vec_valid), .vec(vec)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [3:0] a, input logic [7:0] gi);
    case (a)
      4'd0:  return (m_dir & m_out) | (~m_dir & gi);
      4'd1:  return m_edge;
      4'd2:  return m_dir;
      4'd3:  return m_en[15:8];
      4'd4:  return m_en[7:0];
      4'd5:  return m_pend[15:8];
      4'd6:  return m_pend[7:0];
      4'd7:  return m_srv[15:8];
      4'd8:  return m_srv[7:0];
      4'd9:  return m_mask[15:8];
      4'd10: return m_mask[7:0];
      4'd11: return m_vr;
      default: return 8'h00;
    endcase
  endfunction

  // one clock cycle of stimulus, model update and output checks
  task automatic cyc(input logic [7:0] pe, input logic [7:0] gi, input logic w,
                     input logic [3:0] a, input logic [7:0] d, input logic ack, input string tag);
    logic [15:0] hold, elig, grant, en_n, pend_n, srv_n;
    logic [7:0] pevt, rd_exp, vr_old;
    logic acc, any, sw;
    int id;
    @(negedge clk);
    src_evt = pe; pin_in = gi; reg_wr = w; reg_addr = a; reg_wdata = d; iack = ack;
    rd_exp = m_read(a, gi);
    acc = 1'b0;
    for (int k = 15; k >= 0; k--) begin acc = acc | m_srv[k]; hold[k] = acc; end
    elig = m_pend & m_mask & ~hold;
    any = |elig;
    id = 0;
    for (int k = 0; k < 16; k++) if (elig[k]) id = k;
    grant = any ? (16'd1 << id) : 16'd0;
    pevt = ~m_dir & (m_prev ^ gi) & ~(gi ^ m_edge);
    vr_old = m_vr;
    sw = m_vr[3];
    en_n = m_en; pend_n = m_pend; srv_n = m_srv;
    if (w && a == 3) en_n[15:8] = d;
    if (w && a == 4) en_n[7:0] = d;
    if (w && a == 5) pend_n[15:8] &= d;
    if (w && a == 6) pend_n[7:0] &= d;
    if (w && a == 7) srv_n[15:8] &= d;
    if (w && a == 8) srv_n[7:0] &= d;
    if (ack && any) begin
      pend_n &= ~grant;
      if (sw) srv_n |= grant;
    end
    if (!sw) srv_n = '0;
    pend_n = (pend_n | {pe, pevt}) & en_n;
    m_en = en_n; m_pend = pend_n; m_srv = srv_n;
    if (w && a == 0) m_out = d;
    if (w && a == 1) m_edge = d;
    if (w && a == 2) m_dir = d;
    if (w && a == 9) m_mask[15:8] = d;
    if (w && a == 10) m_mask[7:0] = d;
    if (w && a == 11) m_vr = d & 8'hF8;
    m_prev = gi;
    @(posedge clk);
    #1;
    chk(tag, "rdata", 16'(reg_rdata), 16'(rd_exp));
    chk(tag, "irq", 16'(irq), 16'(any));
    chk(tag, "vec_valid", 16'(vec_valid), 16'(ack && any));
    if (ack && any) chk(tag, "vec", 16'(vec), 16'({vr_old[7:4], 4'(id)}));
    chk(tag, "pin_oe", 16'(pin_oe), 16'(m_dir));
    chk(tag, "pin_out", 16'(pin_out), 16'(m_out));
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    cyc(8'h00, g_pins, 1'b1, a, d, 1'b0, tag);
  endtask
  task automatic rd(input logic [3:0] a, input string tag);
    cyc(8'h00, g_pins, 1'b0, a, 8'h00, 1'b0, tag);
  endtask
  task automatic ev(input logic [7:0] pe, input string tag);
    cyc(pe, g_pins, 1'b0, 4'd0, 8'h00, 1'b0, tag);
  endtask
  task automatic ak(input string tag);
    cyc(8'h00, g_pins, 1'b0, 4'd0, 8'h00, 1'b1, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset values across the map, including an unused index
    for (int a = 0; a < 13; a++) begin
      rd(4'(a), "R1");
      chk("R1", "reset literal", 16'(reg_rdata), 16'h0000);
    end

    // R4: enable gates the pending bit, disabling clears it
    ev(8'h01, "R4"); rd(4'd5, "R4");
    chk("R4", "disabled event", 16'(reg_rdata), 16'h00);
    wr(4'd3, 8'h01, "R4"); ev(8'h01, "R4"); rd(4'd5, "R4");
    chk("R4", "enabled event", 16'(reg_rdata), 16'h01);
    wr(4'd3, 8'h00, "R4"); rd(4'd5, "R4");
    chk("R4", "disable clears", 16'(reg_rdata), 16'h00);

    // R3: peripheral event lands in bank A
    wr(4'd3, 8'hFF, "R3"); wr(4'd4, 8'hFF, "R3");
    ev(8'h80, "R3"); rd(4'd5, "R3");
    chk("R3", "bank A bit 7", 16'(reg_rdata), 16'h80);
    rd(4'd6, "R3");
    chk("R3", "bank B empty", 16'(reg_rdata), 16'h00);

    // R5: masked pending latches without request
    chk("R5", "masked irq", 16'(irq), 16'h0);
    wr(4'd9, 8'h80, "R5");
    chk("R5", "irq lags mask", 16'(irq), 16'h0);
    rd(4'd0, "R5");
    chk("R5", "irq after unmask", 16'(irq), 16'h1);

    // R6: priority and vector format
    wr(4'd11, 8'h40, "R6"); wr(4'd1, 8'h08, "R6"); wr(4'd10, 8'hFF, "R6");
    g_pins = 8'h08; rd(4'd0, "R6");
    ak("R6"); chk("R6", "first vector", 16'(vec), 16'h4F);
    ak("R6"); chk("R6", "second vector", 16'(vec), 16'h43);
    ak("R6"); chk("R6", "empty ack", 16'(vec_valid), 16'h0);

    // R2: falling edge, output pins silent, pin data readback
    wr(4'd1, 8'h00, "R2"); g_pins = 8'h00; rd(4'd6, "R2"); rd(4'd6, "R2");
    chk("R2", "falling edge", 16'(reg_rdata), 16'h08);
    wr(4'd6, 8'hF7, "R2"); wr(4'd2, 8'h10, "R2");
    g_pins = 8'h10; rd(4'd6, "R2"); g_pins = 8'h00; rd(4'd6, "R2"); rd(4'd6, "R2");
    chk("R2", "output pin no event", 16'(reg_rdata), 16'h00);
    wr(4'd0, 8'h10, "R2"); rd(4'd0, "R2");
    chk("R2", "pin readback", 16'(reg_rdata), 16'h10);
    chk("R2", "pin_oe", 16'(pin_oe), 16'h10);

    // R9: write-to-clear semantics
    ev(8'h03, "R9"); wr(4'd5, 8'hFF, "R9"); rd(4'd5, "R9");
    chk("R9", "ones keep", 16'(reg_rdata), 16'h03);
    wr(4'd5, 8'hFE, "R9"); rd(4'd5, "R9");
    chk("R9", "zero clears", 16'(reg_rdata), 16'h02);
    wr(4'd5, 8'h00, "R9");

    // R10: event beats simultaneous clear
    cyc(8'h04, g_pins, 1'b1, 4'd5, 8'h00, 1'b0, "R10"); rd(4'd5, "R10");
    chk("R10", "event wins", 16'(reg_rdata), 16'h04);
    wr(4'd5, 8'h00, "R10");

    // R7: software end-of-interrupt hold-off
    wr(4'd9, 8'hFF, "R7"); wr(4'd11, 8'h48, "R7");
    ev(8'h02, "R7"); wr(4'd1, 8'h01, "R7"); g_pins = 8'h01; rd(4'd0, "R7");
    ak("R7"); chk("R7", "vector src9", 16'(vec), 16'h49);
    rd(4'd7, "R7"); chk("R7", "srv src9", 16'(reg_rdata), 16'h02);
    chk("R7", "lower held", 16'(irq), 16'h0);
    ev(8'h10, "R7"); rd(4'd0, "R7");
    chk("R7", "higher passes", 16'(irq), 16'h1);
    ak("R7"); chk("R7", "vector src12", 16'(vec), 16'h4C);
    rd(4'd7, "R7"); chk("R7", "nested srv", 16'(reg_rdata), 16'h12);
    wr(4'd7, 8'hEF, "R7"); wr(4'd7, 8'hFD, "R7"); rd(4'd0, "R7");
    chk("R7", "released", 16'(irq), 16'h1);
    ak("R7"); chk("R7", "vector src0", 16'(vec), 16'h40);
    rd(4'd8, "R7"); chk("R7", "srv src0", 16'(reg_rdata), 16'h01);

    // R8: automatic mode empties in-service
    wr(4'd11, 8'h40, "R8"); rd(4'd0, "R8"); rd(4'd8, "R8");
    chk("R8", "auto srv", 16'(reg_rdata), 16'h00);

    // random mix checked against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] pe;
      r = int'($urandom % 100);
      pe = ($urandom % 4 == 0) ? 8'($urandom & $urandom & $urandom) : 8'h00;
      if ($urandom % 16 == 0) g_pins = g_pins ^ (8'h01 << ($urandom % 8));
      if (r < 25)
        cyc(pe, g_pins, 1'b1, 4'($urandom % 13), 8'($urandom), 1'b0, "R9");
      else if (r < 45)
        cyc(pe, g_pins, 1'b0, 4'($urandom % 13), 8'h00, 1'b1, "R6");
      else
        cyc(pe, g_pins, 1'b0, 4'($urandom % 13), 8'h00, 1'b0, "R4");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule